// File: doc/BRIEF.md
# Kernel Segment Address Classifier

This stage sits in front of a translation lookaside buffer and sorts every virtual address before any lookup happens. Two fixed kernel windows skip translation: their physical address comes from clearing the three top address bits. One of those windows is reserved for kernel mode. The other is open to any mode. Every other address goes on to the TLB unchanged.

The stage also checks each access for alignment against its size and for a user-mode access to the reserved window. Either violation turns the access into an address-error fault that carries the offending virtual address. A fault outranks both the bypass route and the TLB route. Instruction fetches get one fault code and data accesses get another. The stage also marks accesses as uncached from two virtual address bits alone.

Each request is presented for one cycle with a valid strobe. The result appears on registered outputs one clock later.

Top module: `ksc_classifier`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `req_valid` high. When no request is accepted, all result outputs hold their previous values.
- R2: An aligned access with address bits [31:29] = 3'b100, made in kernel mode, is bypassed: `out_bypass`=1 and `out_addr` = vaddr & 0x1FFFFFFF.
- R3: An access with address bits [31:29] = 3'b100 while `req_kernel`=0 raises an address-error fault, with `out_addr` = vaddr.
- R4: An aligned access with address bits [31:29] = 3'b101 is bypassed with the same mapping, whatever the value of `req_kernel`.
- R5: `req_size` gives the log2 of the access byte count (0: 1 byte, 1: 2, 2: 4, 3: 8). An access is misaligned when vaddr & ((1<<req_size)-1) is nonzero. A misaligned access faults in every segment, and `out_addr` = vaddr.
- R6: `out_fault` is 2'b00 for no fault. It is 2'b01 for a fault on a fetch (`req_kind`=2'b00). It is 2'b10 for a fault on a data access (`req_kind` 2'b01 load, 2'b10 store, 2'b11 treated as data).
- R7: `out_uncached` is 1 exactly when vaddr bits 31 and 29 are both set. This holds whatever route or fault the access takes.
- R8: An address in neither bypass window that does not fault is forwarded: `out_to_tlb`=1 and `out_addr` = vaddr.
- R9: For every result, exactly one of `out_bypass`, `out_to_tlb` and a nonzero `out_fault` is set. A fault wins over both routes.
- R10: While reset is held, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store |
| req_kernel | input | 1 | Kernel mode flag |
| out_valid | output | 1 | Result strobe, one clock after request |
| out_bypass | output | 1 | Address bypasses the TLB |
| out_to_tlb | output | 1 | Address forwarded to the TLB |
| out_uncached | output | 1 | Access is uncacheable |
| out_fault | output | 2 | Address-error code |
| out_addr | output | 32 | Physical, forwarded virtual, or bad virtual address |

## Verification
Two functions can fall on the same access, and the bench provokes both pairings. A bypass-window hit can coincide with an address error: a misaligned access in the open window, an aligned user access in the reserved window, or a misaligned kernel access in the reserved window. In these cases the bench expects the fault code and the raw virtual address, never the bypass route. The uncached flag can also coincide with a fault or with TLB forwarding, at addresses such as 0xA0000002 and 0xE0000000. There the bench expects the flag to stay set beside the fault or the forward route.

// File: rtl/ksc_pkg.sv
package ksc_pkg;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_LOAD  = 2'b01,
    KIND_STORE = 2'b10,
    KIND_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_FETCH_AE = 2'b01,
    FLT_DATA_AE  = 2'b10
  } fault_e;

  typedef struct packed {
    logic   bypass;
    logic   to_tlb;
    logic   uncached;
    fault_e fault;
  } route_t;

endpackage

// File: rtl/ksc_segdec.sv
module ksc_segdec #(
  parameter int          VA_W      = 32,
  parameter int          SEG_W     = 3,
  parameter logic [SEG_W-1:0] SEG_PRIV = 3'b100,
  parameter logic [SEG_W-1:0] SEG_OPEN = 3'b101,
  parameter logic [VA_W-1:0]  UNC_MASK = 32'hA000_0000
) (
  input  logic [VA_W-1:0] vaddr,
  output logic            in_priv,
  output logic            in_open,
  output logic            uncached,
  output logic [VA_W-1:0] phys
);
  localparam int OFF_W = VA_W - SEG_W;

  logic [SEG_W-1:0] seg;

  always_comb begin
    seg      = vaddr[VA_W-1 -: SEG_W];
    in_priv  = (seg == SEG_PRIV);
    in_open  = (seg == SEG_OPEN);
    uncached = ((vaddr & UNC_MASK) == UNC_MASK);
    phys     = {{SEG_W{1'b0}}, vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/ksc_checks.sv
module ksc_checks #(
  parameter int VA_W   = 32,
  parameter int SIZE_W = 2
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [SIZE_W-1:0] size,
  input  logic              kernel,
  input  logic              in_priv,
  output logic              misaligned,
  output logic              priv_viol
);
  localparam int OFF_W = (1 << SIZE_W) - 1;

  logic [OFF_W-1:0] low_mask;

  generate
    for (genvar g = 0; g < OFF_W; g++) begin : g_mask
      assign low_mask[g] = (g < int'(size));
    end
  endgenerate

  always_comb begin
    misaligned = |(vaddr[OFF_W-1:0] & low_mask);
    priv_viol  = in_priv & ~kernel;
  end
endmodule

// File: rtl/ksc_prio.sv
module ksc_prio
  import ksc_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [VA_W-1:0] phys,
  input  logic [1:0]      kind,
  input  logic            in_priv,
  input  logic            in_open,
  input  logic            uncached,
  input  logic            misaligned,
  input  logic            priv_viol,
  output route_t          route,
  output logic [VA_W-1:0] addr
);
  logic addr_err;

  always_comb begin
    addr_err       = misaligned | priv_viol;
    route.uncached = uncached;
    route.bypass   = 1'b0;
    route.to_tlb   = 1'b0;
    route.fault    = FLT_NONE;
    addr           = vaddr;
    if (addr_err) begin
      route.fault = (kind == KIND_FETCH) ? FLT_FETCH_AE : FLT_DATA_AE;
    end else if (in_priv | in_open) begin
      route.bypass = 1'b1;
      addr         = phys;
    end else begin
      route.to_tlb = 1'b1;
    end
  end
endmodule

// File: rtl/ksc_classifier.sv
module ksc_classifier
  import ksc_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [1:0]        req_kind,
  input  logic              req_kernel,
  output logic              out_valid,
  output logic              out_bypass,
  output logic              out_to_tlb,
  output logic              out_uncached,
  output logic [1:0]        out_fault,
  output logic [VA_W-1:0]   out_addr
);
  logic            in_priv, in_open, uncached, misaligned, priv_viol;
  logic [VA_W-1:0] phys, addr_c;
  route_t          route_c;

  logic            valid_q, valid_d;
  route_t          route_q, route_d;
  logic [VA_W-1:0] addr_q, addr_d;

  ksc_segdec #(.VA_W(VA_W)) u_seg (
    .vaddr(req_vaddr), .in_priv(in_priv), .in_open(in_open),
    .uncached(uncached), .phys(phys)
  );

  ksc_checks #(.VA_W(VA_W), .SIZE_W(SIZE_W)) u_chk (
    .vaddr(req_vaddr), .size(req_size), .kernel(req_kernel),
    .in_priv(in_priv), .misaligned(misaligned), .priv_viol(priv_viol)
  );

  ksc_prio #(.VA_W(VA_W)) u_prio (
    .vaddr(req_vaddr), .phys(phys), .kind(req_kind),
    .in_priv(in_priv), .in_open(in_open), .uncached(uncached),
    .misaligned(misaligned), .priv_viol(priv_viol),
    .route(route_c), .addr(addr_c)
  );

  always_comb begin
    valid_d = req_valid;
    route_d = route_q;
    addr_d  = addr_q;
    if (req_valid) begin
      route_d = route_c;
      addr_d  = addr_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      route_q <= '0;
      addr_q  <= '0;
    end else begin
      valid_q <= valid_d;
      route_q <= route_d;
      addr_q  <= addr_d;
    end
  end

  assign out_valid    = valid_q;
  assign out_bypass   = route_q.bypass;
  assign out_to_tlb   = route_q.to_tlb;
  assign out_uncached = route_q.uncached;
  assign out_fault    = route_q.fault;
  assign out_addr     = addr_q;
endmodule

// File: rtl/ksc_classifier_chk.sv
module ksc_classifier_chk #(
  parameter int VA_W   = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [SIZE_W-1:0] req_size,
  input logic [1:0]        req_kind,
  input logic              req_kernel,
  input logic              out_valid,
  input logic              out_bypass,
  input logic              out_to_tlb,
  input logic              out_uncached,
  input logic [1:0]        out_fault,
  input logic [VA_W-1:0]   out_addr
);
  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  // R1
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_fault)));
  // R9
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_bypass, out_to_tlb, out_fault != 2'b00}) == 1));
  // R3
  user_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[VA_W-1 -: 3] == 3'b100 && !req_kernel)
      |=> (out_fault != 2'b00 && out_addr == $past(req_vaddr)));
  // R5
  odd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[0] && req_size != '0)
      |=> (out_fault != 2'b00 && !out_bypass && !out_to_tlb));
  // R6
  fetch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'b00) |=> (out_fault != 2'b10));
  // R6
  data_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind != 2'b00) |=> (out_fault != 2'b01));
  // R7
  uncached_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_uncached == ($past(req_vaddr[VA_W-1]) && $past(req_vaddr[VA_W-3]))));
endmodule

bind ksc_classifier ksc_classifier_chk #(.VA_W(VA_W), .SIZE_W(SIZE_W)) u_bind_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_size(req_size), .req_kind(req_kind), .req_kernel(req_kernel),
  .out_valid(out_valid), .out_bypass(out_bypass), .out_to_tlb(out_to_tlb),
  .out_uncached(out_uncached), .out_fault(out_fault), .out_addr(out_addr)
);

// File: tb/sim_ksc_classifier.sv
`timescale 1ns/1ps
module sim_ksc_classifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_size;
  logic [1:0]  req_kind;
  logic        req_kernel;
  logic        out_valid, out_bypass, out_to_tlb, out_uncached;
  logic [1:0]  out_fault;
  logic [31:0] out_addr;

  typedef struct {
    logic        bypass;
    logic        to_tlb;
    logic        unc;
    logic [1:0]  fault;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  always #10 clk = ~clk;

  ksc_classifier u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_kind(req_kind), .req_kernel(req_kernel),
    .out_valid(out_valid), .out_bypass(out_bypass), .out_to_tlb(out_to_tlb),
    .out_uncached(out_uncached), .out_fault(out_fault), .out_addr(out_addr)
  );

  function automatic exp_t model(logic [31:0] va, logic [1:0] sz, logic [1:0] kd,
                                 logic kern, string tag);
    exp_t e;
    logic mis, k_priv, k_open;
    mis    = ((va & ((32'd1 << sz) - 32'd1)) != 0);
    k_priv = (va[31:29] == 3'b100);
    k_open = (va[31:29] == 3'b101);
    e.unc = va[31] & va[29];
    e.bypass = 0; e.to_tlb = 0; e.fault = 2'b00; e.addr = va; e.tag = tag;
    if (mis || (k_priv && !kern)) e.fault = (kd == 2'b00) ? 2'b01 : 2'b10;
    else if (k_priv || k_open) begin e.bypass = 1; e.addr = va & 32'h1FFF_FFFF; end
    else e.to_tlb = 1;
    return e;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] va, logic [1:0] sz, logic [1:0] kd,
                       logic kern, string tag);
    @(negedge clk);
    q.push_back(model(va, sz, kd, kern, tag));
    req_valid = 1; req_vaddr = va; req_size = sz; req_kind = kd; req_kernel = kern;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // monitor: compare results against scoreboard
  logic expect_out = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      check("R1", {63'd0, out_valid}, {63'd0, expect_out}, "valid strobe");
      if (out_valid) begin
        if (q.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL R1 unexpected result: actual 1 expected 0");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, {63'd0, out_bypass}, {63'd0, e.bypass}, "bypass");
          check(e.tag, {63'd0, out_to_tlb}, {63'd0, e.to_tlb}, "to_tlb");
          check("R7",  {63'd0, out_uncached}, {63'd0, e.unc}, "uncached");
          check("R6",  {62'd0, out_fault}, {62'd0, e.fault}, "fault code");
          check(e.tag, {32'd0, out_addr}, {32'd0, e.addr}, "addr");
        end
      end
      expect_out = req_valid;
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; req_valid = 0; req_vaddr = 0; req_size = 0; req_kind = 0; req_kernel = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {26'd0, out_valid, out_bypass, out_to_tlb, out_uncached, out_fault, out_addr},
          64'd0, "reset outputs");
    rst_n = 1;
    idle(2);
    drive(32'h8000_1000, 2'd2, 2'b00, 1, "R2");   // kernel bypass, cached
    drive(32'h9FFF_FFFF, 2'd0, 2'b01, 1, "R2");   // top of window
    drive(32'h8000_1000, 2'd2, 2'b00, 0, "R3");   // user in reserved window, fetch
    drive(32'h8000_0040, 2'd2, 2'b10, 0, "R3");   // user, store
    drive(32'hA000_0004, 2'd2, 2'b01, 0, "R4");   // open window user
    drive(32'hBFFF_FFF8, 2'd3, 2'b10, 1, "R4");   // dword, uncached
    drive(32'hA000_0002, 2'd2, 2'b10, 1, "R5");   // misaligned in open window
    drive(32'h8000_0001, 2'd1, 2'b00, 1, "R5");   // half misaligned fetch
    drive(32'h8000_0004, 2'd3, 2'b01, 1, "R9");   // dword misaligned in bypass
    drive(32'h0040_0003, 2'd0, 2'b01, 0, "R5");   // byte never misaligned
    drive(32'h0040_0006, 2'd2, 2'b11, 0, "R6");   // reserved kind = data code
    drive(32'h0040_0000, 2'd2, 2'b00, 0, "R8");
    drive(32'hE000_0000, 2'd2, 2'b01, 1, "R8");   // mapped but uncached
    drive(32'hC000_0000, 2'd2, 2'b10, 1, "R8");
    drive(32'h7FFF_FFFF, 2'd0, 2'b00, 0, "R8");
    idle(1);
    held = out_addr;
    idle(3);
    // R1 outputs hold with no request
    check("R1", {32'd0, out_addr}, {32'd0, held}, "hold addr");
    drive(32'hA000_0008, 2'd3, 2'b00, 0, "R4");
    drive(32'h2000_0010, 2'd1, 2'b10, 0, "R8");
    idle(4);
    check("R1", {32'd0, q.size()}, 64'd0, "scoreboard drained");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule